// File: doc/BRIEF.md
# Indexed Command/Data Register Port

This block is the host-facing register engine of a display controller that sits on a narrow parallel bus with a command/data select line. The host first issues a command cycle (select low) to pick an 8-bit register index. It then issues one or more data cycles (select high), each storing a 16-bit bus word into the selected register through that register's write mask. After each data cycle the index steps forward by two, so a run of consecutive registers can be programmed from a single command. Three streaming ports keep the index fixed so that a burst lands on one port: the pixel data port, the filter coefficient port and the gamma table port.

The block holds the configuration state. This includes wide fields split across byte-wide registers, a clock divider with an offset encoding, read-only identification bytes, two auto-indexed lookup tables, a status byte with a fixed flag, and an interrupt status byte that hardware events set and the host clears by writing. Reads are side-effect free: the read bus always shows the register at the current index. A data cycle at the pixel port is only forwarded as a strobe with its word, for a downstream pixel engine.

Top module: `regport_top`

## Requirements
- R1: A bus write with cmdSel low loads wrData[7:0] into the register index; the index resets to 0x00.
- R2: A bus write with cmdSel high adds 2 to the index, except when the index is 0x90, 0x5A or 0xB8, where it is left unchanged.
- R3: Index 0x00 reads 0x00A5 and index 0x02 reads 0x0083; data writes there change nothing.
- R4: A data write at 0x04 stores wrData[5:0] plus one; a read at 0x04 returns the stored value minus one with bit 7 set (reset value stored 9, read 0x88).
- R5: Eight 10-bit window coordinates sit at pairs from 0x6C to 0x8A (coordinate n at 0x6C+4n and 0x6E+4n): the even register writes and reads bits 7:0, the odd one writes bits 9:8 from wrData[1:0] and reads them back in bits 1:0.
- R6: Two 12-bit fields, synthesis control at 0x08/0x0A (reset 0x014) and refresh interval at 0x18/0x1A (reset 0x25C), take bits 7:0 from the first register and bits 11:8 from wrData[3:0] of the second; reads return the matching slice.
- R7: 0xB6 sets an 8-bit gamma index; a data write at 0xB8 stores wrData[7:0] into the 256-entry gamma table at that index and increments it, wrapping from 0xFF to 0x00; a read at 0xB8 returns the entry at the index.
- R8: 0x58 sets a filter index from wrData[4:0]; a data write at 0x5A stores wrData[7:0] into the 32-entry filter table and increments the index modulo 32; a read at 0x5A returns the entry at the index.
- R9: A data write at 0x90 drives pixStb high in the same cycle with pixData equal to wrData; pixStb is low otherwise and a read at 0x90 returns 0.
- R10: Interrupt status at 0xF6: each bit set in irqEvent sets the matching status bit at the next edge; a data write there ANDs wrData[7:0] into the status, and an event in the same cycle still sets its bit.
- R11: A data write at 0xE8 stores wrData & 0x1B; a read there returns the stored value with bit 5 always set.
- R12: After reset, 0x28 (panel setup, 8 bits) reads 0x74, 0x8C (input format, low 4 bits) reads 0x03 and 0xF8 (pull-down, 8 bits) reads 0xFF.
- R13: A data write at an unmapped index changes no register, an unmapped index reads 0, and reads never change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Bus write cycle |
| cmdSel | input | 1 | Low: command (index) cycle, high: data cycle |
| wrData | input | 16 | Write data bus |
| rdData | output | 16 | Register at the current index |
| irqEvent | input | 8 | Interrupt event bits, one per status bit |
| pixStb | output | 1 | Pixel data port write strobe |
| pixData | output | 16 | Word forwarded with pixStb |

## Verification
The read bus is combinational from the index register, so a value becomes valid in the cycle right after the command cycle's capturing edge. A register write is visible one edge after its data cycle. The pixel strobe is combinational and is due in the data cycle itself. The bench drives every bus cycle from a falling edge and holds it for one full period. It samples reads one nanosecond after the next falling edge, by which point exactly one rising edge has updated the index or register. It checks pixStb one nanosecond into the data cycle and again after that cycle is released.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic              dataWr;
    logic [IDX_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } hostStrb_t;

  localparam logic [IDX_W-1:0] ADR_ID0       = 8'h00;
  localparam logic [IDX_W-1:0] ADR_ID1       = 8'h02;
  localparam logic [IDX_W-1:0] ADR_DIV       = 8'h04;
  localparam logic [IDX_W-1:0] ADR_SYN_LO    = 8'h08;
  localparam logic [IDX_W-1:0] ADR_SYN_HI    = 8'h0A;
  localparam logic [IDX_W-1:0] ADR_REF_LO    = 8'h18;
  localparam logic [IDX_W-1:0] ADR_REF_HI    = 8'h1A;
  localparam logic [IDX_W-1:0] ADR_PANEL     = 8'h28;
  localparam logic [IDX_W-1:0] ADR_FILT_IDX  = 8'h58;
  localparam logic [IDX_W-1:0] ADR_FILT_DATA = 8'h5A;
  localparam logic [IDX_W-1:0] ADR_WIN_BASE  = 8'h6C;
  localparam logic [IDX_W-1:0] ADR_FMT       = 8'h8C;
  localparam logic [IDX_W-1:0] ADR_PIX       = 8'h90;
  localparam logic [IDX_W-1:0] ADR_GAM_IDX   = 8'hB6;
  localparam logic [IDX_W-1:0] ADR_GAM_DATA  = 8'hB8;
  localparam logic [IDX_W-1:0] ADR_NDSTAT    = 8'hE8;
  localparam logic [IDX_W-1:0] ADR_IRQ       = 8'hF6;
  localparam logic [IDX_W-1:0] ADR_PULLDN    = 8'hF8;

  localparam logic [DATA_W-1:0] ID0_VAL = 16'h00A5;
  localparam logic [DATA_W-1:0] ID1_VAL = 16'h0083;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              cmdSel,
  input  logic [DATA_W-1:0] wrData,
  output hostStrb_t         strb,
  output logic [IDX_W-1:0]  curIdx
);
  localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(2);

  logic holdIdx;
  assign holdIdx = (curIdx == ADR_PIX) || (curIdx == ADR_FILT_DATA) ||
                   (curIdx == ADR_GAM_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (busWr) begin
      if (!cmdSel)       curIdx <= wrData[IDX_W-1:0];
      else if (!holdIdx) curIdx <= curIdx + IDX_STEP;
    end
  end

  assign strb.dataWr = busWr && cmdSel;
  assign strb.addr   = curIdx;
  assign strb.data   = wrData;
endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int GAMMA_DEPTH = 256,
  parameter int FILT_DEPTH  = 32,
  parameter int COORD_W     = 10,
  parameter int NUM_COORD   = 8,
  parameter int IRQ_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IRQ_W-1:0]  irqEvent,
  output logic [DATA_W-1:0] rdData,
  output logic              pixStb,
  output logic [DATA_W-1:0] pixData,
  output logic [IRQ_W-1:0]  irqPending
);
  localparam int GIDX_W = $clog2(GAMMA_DEPTH);
  localparam int FIDX_W = $clog2(FILT_DEPTH);
  localparam int CHI_W  = COORD_W - 8;

  // write decode
  logic hitDiv, hitSynLo, hitSynHi, hitRefLo, hitRefHi, hitPanel, hitFmt;
  logic hitFiltIdx, hitFiltData, hitGamIdx, hitGamData, hitNd, hitIrq, hitPull;
  assign hitDiv      = strb.dataWr && strb.addr == ADR_DIV;
  assign hitSynLo    = strb.dataWr && strb.addr == ADR_SYN_LO;
  assign hitSynHi    = strb.dataWr && strb.addr == ADR_SYN_HI;
  assign hitRefLo    = strb.dataWr && strb.addr == ADR_REF_LO;
  assign hitRefHi    = strb.dataWr && strb.addr == ADR_REF_HI;
  assign hitPanel    = strb.dataWr && strb.addr == ADR_PANEL;
  assign hitFmt      = strb.dataWr && strb.addr == ADR_FMT;
  assign hitFiltIdx  = strb.dataWr && strb.addr == ADR_FILT_IDX;
  assign hitFiltData = strb.dataWr && strb.addr == ADR_FILT_DATA;
  assign hitGamIdx   = strb.dataWr && strb.addr == ADR_GAM_IDX;
  assign hitGamData  = strb.dataWr && strb.addr == ADR_GAM_DATA;
  assign hitNd       = strb.dataWr && strb.addr == ADR_NDSTAT;
  assign hitIrq      = strb.dataWr && strb.addr == ADR_IRQ;
  assign hitPull     = strb.dataWr && strb.addr == ADR_PULLDN;

  assign pixStb  = strb.dataWr && strb.addr == ADR_PIX;
  assign pixData = strb.data;

  // scalar configuration state
  logic [6:0]       divReg;
  logic [11:0]      synCtl;
  logic [11:0]      refIntv;
  logic [7:0]       panelCfg;
  logic [3:0]       fmtSel;
  logic [7:0]       ndStat;
  logic [7:0]       pullDn;
  logic [IRQ_W-1:0] irqSt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= 7'd9;
      synCtl   <= 12'h014;
      refIntv  <= 12'h25C;
      panelCfg <= 8'h74;
      fmtSel   <= 4'h3;
      ndStat   <= 8'h00;
      pullDn   <= 8'hFF;
      irqSt    <= '0;
    end else begin
      if (hitDiv)   divReg        <= {1'b0, strb.data[5:0]} + 7'd1;
      if (hitSynLo) synCtl[7:0]   <= strb.data[7:0];
      if (hitSynHi) synCtl[11:8]  <= strb.data[3:0];
      if (hitRefLo) refIntv[7:0]  <= strb.data[7:0];
      if (hitRefHi) refIntv[11:8] <= strb.data[3:0];
      if (hitPanel) panelCfg      <= strb.data[7:0];
      if (hitFmt)   fmtSel        <= strb.data[3:0];
      if (hitNd)    ndStat        <= strb.data[7:0] & 8'h1B;
      if (hitPull)  pullDn        <= strb.data[7:0];
      irqSt <= (hitIrq ? (irqSt & strb.data[IRQ_W-1:0]) : irqSt) | irqEvent;
    end
  end

  assign irqPending = irqSt;

  // window coordinates, one low/high register pair each
  logic [COORD_W-1:0] coord [NUM_COORD];

  for (genvar c = 0; c < NUM_COORD; c++) begin : g_coord
    localparam logic [IDX_W-1:0] LO_ADR = IDX_W'(ADR_WIN_BASE + 4 * c);
    localparam logic [IDX_W-1:0] HI_ADR = IDX_W'(ADR_WIN_BASE + 4 * c + 2);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        coord[c] <= '0;
      end else if (strb.dataWr) begin
        if (strb.addr == LO_ADR) coord[c][7:0]         <= strb.data[7:0];
        if (strb.addr == HI_ADR) coord[c][COORD_W-1:8] <= strb.data[CHI_W-1:0];
      end
    end
  end

  // auto-indexed lookup tables
  logic [7:0]        gamTab [GAMMA_DEPTH];
  logic [GIDX_W-1:0] gamIdx;
  logic [7:0]        filtTab [FILT_DEPTH];
  logic [FIDX_W-1:0] filtIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GAMMA_DEPTH; i++) gamTab[i] <= '0;
      gamIdx <= '0;
    end else if (hitGamIdx) begin
      gamIdx <= strb.data[GIDX_W-1:0];
    end else if (hitGamData) begin
      gamTab[gamIdx] <= strb.data[7:0];
      gamIdx         <= gamIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FILT_DEPTH; i++) filtTab[i] <= '0;
      filtIdx <= '0;
    end else if (hitFiltIdx) begin
      filtIdx <= strb.data[FIDX_W-1:0];
    end else if (hitFiltData) begin
      filtTab[filtIdx] <= strb.data[7:0];
      filtIdx          <= filtIdx + 1'b1;
    end
  end

  // read mux, combinational from the current index
  always_comb begin
    unique case (rdIdx)
      ADR_ID0:       rdData = ID0_VAL;
      ADR_ID1:       rdData = ID1_VAL;
      ADR_DIV:       rdData = DATA_W'({1'b1, 7'(divReg - 7'd1)});
      ADR_SYN_LO:    rdData = DATA_W'(synCtl[7:0]);
      ADR_SYN_HI:    rdData = DATA_W'(synCtl[11:8]);
      ADR_REF_LO:    rdData = DATA_W'(refIntv[7:0]);
      ADR_REF_HI:    rdData = DATA_W'(refIntv[11:8]);
      ADR_PANEL:     rdData = DATA_W'(panelCfg);
      ADR_FILT_IDX:  rdData = DATA_W'(filtIdx);
      ADR_FILT_DATA: rdData = DATA_W'(filtTab[filtIdx]);
      ADR_FMT:       rdData = DATA_W'(fmtSel);
      ADR_GAM_IDX:   rdData = DATA_W'(gamIdx);
      ADR_GAM_DATA:  rdData = DATA_W'(gamTab[gamIdx]);
      ADR_NDSTAT:    rdData = DATA_W'(ndStat | 8'h20);
      ADR_IRQ:       rdData = DATA_W'(irqSt);
      ADR_PULLDN:    rdData = DATA_W'(pullDn);
      default:       rdData = '0;
    endcase
    for (int c = 0; c < NUM_COORD; c++) begin
      if (rdIdx == IDX_W'(ADR_WIN_BASE + 4 * c))     rdData = DATA_W'(coord[c][7:0]);
      if (rdIdx == IDX_W'(ADR_WIN_BASE + 4 * c + 2)) rdData = DATA_W'(coord[c][COORD_W-1:8]);
    end
  end
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int GAMMA_DEPTH = 256,
  parameter int FILT_DEPTH  = 32,
  parameter int COORD_W     = 10,
  parameter int NUM_COORD   = 8,
  parameter int IRQ_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              cmdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [IRQ_W-1:0]  irqEvent,
  output logic              pixStb,
  output logic [DATA_W-1:0] pixData
);
  hostStrb_t        strb;
  logic [IDX_W-1:0] curIdx;
  logic [IRQ_W-1:0] irqPending;

  regport_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .busWr  (busWr),
    .cmdSel (cmdSel),
    .wrData (wrData),
    .strb   (strb),
    .curIdx (curIdx)
  );

  regport_dp #(
    .GAMMA_DEPTH (GAMMA_DEPTH),
    .FILT_DEPTH  (FILT_DEPTH),
    .COORD_W     (COORD_W),
    .NUM_COORD   (NUM_COORD),
    .IRQ_W       (IRQ_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdIdx      (curIdx),
    .irqEvent   (irqEvent),
    .rdData     (rdData),
    .pixStb     (pixStb),
    .pixData    (pixData),
    .irqPending (irqPending)
  );
endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              cmdSel,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [IDX_W-1:0]  curIdx,
  input logic [DATA_W-1:0] rdData,
  input logic [IRQ_W-1:0]  irqMask,
  input logic [IRQ_W-1:0]  irqEvent,
  input logic [IRQ_W-1:0]  irqPending
);
  logic onStream;
  assign onStream = (curIdx == ADR_PIX) || (curIdx == ADR_FILT_DATA) ||
                    (curIdx == ADR_GAM_DATA);

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !cmdSel |=> curIdx == $past(wrIdx));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && cmdSel && !onStream |=> curIdx == IDX_W'($past(curIdx) + 8'd2));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && cmdSel && onStream |=> $stable(curIdx));

  // R3
  ident_chk: assert property (@(posedge clk) disable iff (!rstN)
    curIdx == ADR_ID0 |-> rdData == ID0_VAL);

  // R11
  nd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    curIdx == ADR_NDSTAT |-> rdData[5]);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && cmdSel && curIdx == ADR_IRQ |=>
      (irqPending & ~(($past(irqPending) & $past(irqMask)) | $past(irqEvent))) == '0);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent != '0 |=> (irqPending & $past(irqEvent)) == $past(irqEvent));
endmodule

bind regport_top regport_chk #(.IRQ_W(IRQ_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .cmdSel     (cmdSel),
  .wrIdx      (wrData[7:0]),
  .curIdx     (curIdx),
  .rdData     (rdData),
  .irqMask    (wrData[IRQ_W-1:0]),
  .irqEvent   (irqEvent),
  .irqPending (irqPending)
);

// File: tb/regport_tb.sv
module regport_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        cmdSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  irqEvent = '0;
  logic [15:0] rdData;
  logic        pixStb;
  logic [15:0] pixData;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regport_top dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .cmdSel(cmdSel), .wrData(wrData),
    .rdData(rdData), .irqEvent(irqEvent), .pixStb(pixStb), .pixData(pixData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [15:0] v);
    @(negedge clk); busWr = 1'b1; cmdSel = 1'b0; wrData = v;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic dat(input logic [15:0] v);
    @(negedge clk); busWr = 1'b1; cmdSel = 1'b1; wrData = v;
    @(negedge clk); busWr = 1'b0;
  endtask

  // select an index, then sample the combinational read one ns later
  task automatic rdAt(input logic [7:0] idx, input logic [15:0] exp, input string req);
    cmd({8'h00, idx});
    #1;
    check(req, rdData, exp);
  endtask

  task automatic testReset();
    rdAt(8'h18, 16'h005C, "R12/R6 refresh lo reset");
    rdAt(8'h1A, 16'h0002, "R12/R6 refresh hi reset");
    rdAt(8'h08, 16'h0014, "R6 synth lo reset");
    rdAt(8'h0A, 16'h0000, "R6 synth hi reset");
    rdAt(8'h28, 16'h0074, "R12 panel reset");
    rdAt(8'h8C, 16'h0003, "R12 format reset");
    rdAt(8'hF8, 16'h00FF, "R12 pulldown reset");
    rdAt(8'h04, 16'h0088, "R4 divider reset");
    rdAt(8'hF6, 16'h0000, "R10 irq reset");
  endtask

  task automatic testIdent();
    rdAt(8'h00, 16'h00A5, "R3 id0");
    rdAt(8'h02, 16'h0083, "R3 id1");
    cmd(16'h0000); dat(16'h1234); dat(16'h5678);
    rdAt(8'h00, 16'h00A5, "R3 id0 after write");
    rdAt(8'h02, 16'h0083, "R3 id1 after write");
  endtask

  task automatic testAdvanceCoords();
    // R1: upper bus bits ignored in command cycle; R2: four writes via one command
    cmd(16'hFF6C);
    dat(16'h0034); dat(16'h00FF); dat(16'h0156); dat(16'h0002);
    #1; check("R2 index after four steps", rdData, 16'h0000); // now at 0x74, coord 2 lo = 0
    rdAt(8'h6C, 16'h0034, "R5 coord0 lo");
    rdAt(8'h6E, 16'h0003, "R5 coord0 hi");
    rdAt(8'h70, 16'h0056, "R5 coord1 lo");
    rdAt(8'h72, 16'h0002, "R5 coord1 hi");
    cmd(16'h0088); dat(16'h00AB); dat(16'h0001);
    rdAt(8'h88, 16'h00AB, "R5 coord7 lo");
    rdAt(8'h8A, 16'h0001, "R5 coord7 hi");
    cmd(16'h0028); dat(16'h0011); dat(16'h0000);
    rdAt(8'h28, 16'h0011, "R1/R2 panel via step");
  endtask

  task automatic testDivSplit();
    cmd(16'h0004); dat(16'h00FF);
    rdAt(8'h04, 16'h00BF, "R4 divider max");
    cmd(16'h0004); dat(16'h0000);
    rdAt(8'h04, 16'h0080, "R4 divider zero");
    cmd(16'h0018); dat(16'hABCD); dat(16'hFFF7);
    rdAt(8'h18, 16'h00CD, "R6 refresh lo");
    rdAt(8'h1A, 16'h0007, "R6 refresh hi");
    cmd(16'h000A); dat(16'h003C);
    rdAt(8'h0A, 16'h000C, "R6 synth hi");
    rdAt(8'h08, 16'h0014, "R6 synth lo kept");
  endtask

  task automatic testGamma();
    cmd(16'h00B6); dat(16'h0010);
    cmd(16'h00B8); dat(16'h0011); dat(16'h0022); dat(16'h0033);
    #1; check("R2 index held at gamma port", rdData, 16'h0000);
    rdAt(8'hB6, 16'h0013, "R7 gamma index advanced");
    cmd(16'h00B6); dat(16'h0011);
    rdAt(8'hB8, 16'h0022, "R7 gamma entry");
    cmd(16'h00B6); dat(16'h00FF);
    cmd(16'h00B8); dat(16'h005A); dat(16'h006B);
    rdAt(8'hB6, 16'h0001, "R7 gamma index wrap");
    cmd(16'h00B6); dat(16'h0000);
    rdAt(8'hB8, 16'h006B, "R7 gamma wrapped entry");
    #1; check("R13 read without side effect", rdData, 16'h006B);
    rdAt(8'hB6, 16'h0000, "R13 gamma index unchanged by read");
  endtask

  task automatic testFilter();
    cmd(16'h0058); dat(16'h003F);  // index steps on to 0x5A
    dat(16'h0077); dat(16'h0088);
    rdAt(8'h58, 16'h0001, "R8 filter index wrap");
    cmd(16'h0058); dat(16'h001F);
    #1; check("R8 filter entry 31", rdData, 16'h0077);
    cmd(16'h0058); dat(16'h0000);
    #1; check("R8 filter entry 0", rdData, 16'h0088);
  endtask

  task automatic testPixel();
    cmd(16'h0090);
    #1; check("R9 pixStb idle", {15'd0, pixStb}, 16'h0001 ^ 16'h0001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); busWr = 1'b1; cmdSel = 1'b1; wrData = 16'hC000 + 16'(k);
      #1;
      check("R9 pixStb on data write", {15'd0, pixStb}, 16'h0001);
      check("R9 pixData", pixData, 16'hC000 + 16'(k));
      @(negedge clk); busWr = 1'b0;
      #1; check("R9 pixStb released", {15'd0, pixStb}, 16'h0000);
    end
    check("R9 read at pixel port", rdData, 16'h0000);
  endtask

  task automatic testStatus();
    cmd(16'h00E8); dat(16'h00FF);
    rdAt(8'hE8, 16'h003B, "R11 status mask plus bit5");
    cmd(16'h00E8); dat(16'h0000);
    rdAt(8'hE8, 16'h0020, "R11 status bit5 forced");
    @(negedge clk); irqEvent = 8'hF0;
    @(negedge clk); irqEvent = 8'h00;
    rdAt(8'hF6, 16'h00F0, "R10 irq set");
    cmd(16'h00F6); dat(16'h0030);
    rdAt(8'hF6, 16'h0030, "R10 irq and-clear");
    cmd(16'h00F6);
    @(negedge clk); busWr = 1'b1; cmdSel = 1'b1; wrData = 16'h0000; irqEvent = 8'h01;
    @(negedge clk); busWr = 1'b0; irqEvent = 8'h00;
    rdAt(8'hF6, 16'h0001, "R10 event wins over clear");
  endtask

  task automatic testUnmapped();
    cmd(16'h0012); dat(16'hFFFF); dat(16'hFFFF);
    rdAt(8'h12, 16'h0000, "R13 unmapped read");
    rdAt(8'h14, 16'h0000, "R13 unmapped read 2");
    rdAt(8'h28, 16'h0011, "R13 panel untouched");
    rdAt(8'h18, 16'h00CD, "R13 refresh untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1; check("R1 index reset reads id0", rdData, 16'h00A5);
    testReset();
    testIdent();
    testAdvanceCoords();
    testDivSplit();
    testGamma();
    testFilter();
    testPixel();
    testStatus();
    testUnmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule